// File: doc/BRIEF.md
# Block-Transfer Link Responder (card side)

This block sits behind the byte receiver of a card that speaks the half-duplex block-transfer smart-card protocol. It is given one already-classified incoming frame at a time: the address byte, the control byte, the first information byte and a flag saying that the check byte or the parity of some byte was wrong. For the cases that need no application data, it builds the card's reply frame itself. Those cases are acknowledging a chained information block, reporting a damaged frame, and answering supervisory requests. The reply leaves on a valid/ready byte stream, with the XOR check byte computed as the bytes go out.

The reply address is always the received address with its nibbles exchanged. The address is not validated. The block keeps the information-field size and the block-wait multiplier that supervisory requests set. It also tracks whether a chain from the host is open and the sequence bit of the last information block. An unchained information block draws no reply from this block. Instead, a one-cycle request tells the application layer that it must answer. A programmable number of idle clock cycles always precedes the first reply byte, so that the shared line has time to turn around.

Top module: `t1_link_responder`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, ifs_cur is 0x20, wtx_cur is 0x01, chain_open is 0 and seq_last is 0.
- R2: Every reply begins with the received address byte with its high and low nibbles exchanged, for any address value.
- R3: A clean information block (control bit 7 = 0, sequence bit = bit 6, chain bit = bit 5) with the chain bit set is answered with control 0x80 when bit 6 is 0, or 0x90 when bit 6 is 1, and length 0. It sets chain_open and loads seq_last with bit 6.
- R4: A frame flagged in_bad is answered with control 0x81, or 0x91 when it is an information block with bit 6 set, and length 0. It changes none of ifs_cur, wtx_cur, chain_open or seq_last.
- R5: A size request (control 0xC1) is answered with control 0xE1, length 1 and the echoed data byte, and ifs_cur takes that byte.
- R6: A wait-extension request (control 0xC3) is answered with control 0xE3, length 1 and the echoed byte, and wtx_cur takes that byte.
- R7: A resync request (control 0xC0) is answered with control 0xE0 and length 0. It restores ifs_cur to 0x20 and wtx_cur to 0x01, and clears chain_open and seq_last.
- R8: An abort request (control 0xC2) is answered with control 0xE2 and length 0, and clears chain_open.
- R9: A clean unchained information block produces no reply bytes. It pulses app_req for exactly one cycle after acceptance, clears chain_open and loads seq_last with bit 6.
- R10: Receive-ready blocks (bits 7:6 = 10) and supervisory responses (bits 7:5 = 111) produce no reply and change no state. in_ready stays 1.
- R11: The final reply byte is the XOR of all preceding reply bytes, and out_last is high on that byte only.
- R12: The first reply byte is not offered until at least guard_cycles+1 clock cycles after the frame is accepted.
- R13: While out_valid is high and out_ready is low, out_data holds. in_ready stays low from acceptance until the reply completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| guard_cycles | input | 16 | Idle cycles inserted before a reply |
| in_valid | input | 1 | Classified frame present |
| in_ready | output | 1 | Block can accept a frame |
| in_nad | input | 8 | Received address byte |
| in_pcb | input | 8 | Received control byte |
| in_data | input | 8 | First information byte of the received frame |
| in_bad | input | 1 | Check byte or parity error seen in the frame |
| out_valid | output | 1 | Reply byte present |
| out_ready | input | 1 | Downstream takes the reply byte |
| out_data | output | 8 | Reply byte |
| out_last | output | 1 | Current byte is the check byte |
| app_req | output | 1 | One-cycle request for an application reply |
| ifs_cur | output | 8 | Current information-field size |
| wtx_cur | output | 8 | Current block-wait multiplier |
| chain_open | output | 1 | A host chain is in progress |
| seq_last | output | 1 | Sequence bit of the last information block |

## Verification
Information blocks are sent with both sequence values, with and without the chain bit, and with the error flag. These runs separate the acknowledge codes from the error codes and show that the sequence bit is mirrored into the right position. All four supervisory request types are sent with distinct data bytes, so a swapped type decode or a missing echo gives a wrong frame or wrong stored state. Blocks that must be ignored are interleaved with stored non-default state to show that nothing moves. Guard values of zero and twenty, together with a downstream that stalls every other cycle, expose timing faults and byte-holding faults.

// File: rtl/t1r_pkg.sv
package t1r_pkg;

  typedef enum logic [1:0] {
    SREQ_RESYNC = 2'b00,
    SREQ_SIZE   = 2'b01,
    SREQ_ABORT  = 2'b10,
    SREQ_WAIT   = 2'b11
  } sreq_e;

  typedef struct packed {
    logic       reply;
    logic [7:0] pcb;
    logic       has_data;
    logic       app;
    logic       set_ifs;
    logic       set_wtx;
    logic       resync;
    logic       open_chain;
    logic       close_chain;
    logic       upd_seq;
    logic       seq;
  } act_t;

  function automatic logic [7:0] swap_nibbles(input logic [7:0] b);
    return {b[3:0], b[7:4]};
  endfunction

  function automatic logic [7:0] lrc_step(input logic [7:0] acc, input logic [7:0] b);
    return acc ^ b;
  endfunction

  // Turn one received control byte into a reply descriptor and state actions.
  function automatic act_t decode_frame(input logic [7:0] pcb, input logic bad);
    act_t  a;
    logic  is_info;
    sreq_e kind;
    a       = '0;
    is_info = ~pcb[7];
    kind    = sreq_e'(pcb[1:0]);
    if (bad) begin
      a.reply = 1'b1;
      a.pcb   = {3'b100, is_info & pcb[6], 4'b0001};
    end else if (is_info) begin
      a.upd_seq = 1'b1;
      a.seq     = pcb[6];
      if (pcb[5]) begin
        a.reply      = 1'b1;
        a.pcb        = {3'b100, pcb[6], 4'b0000};
        a.open_chain = 1'b1;
      end else begin
        a.app         = 1'b1;
        a.close_chain = 1'b1;
      end
    end else if (pcb[7:5] == 3'b110) begin
      a.reply = 1'b1;
      a.pcb   = pcb | 8'h20;
      unique case (kind)
        SREQ_RESYNC: a.resync = 1'b1;
        SREQ_SIZE: begin
          a.set_ifs  = 1'b1;
          a.has_data = 1'b1;
        end
        SREQ_ABORT: a.close_chain = 1'b1;
        SREQ_WAIT: begin
          a.set_wtx  = 1'b1;
          a.has_data = 1'b1;
        end
      endcase
    end
    return a;
  endfunction

endpackage

// File: rtl/t1r_classify.sv
module t1r_classify
  import t1r_pkg::*;
(
  input  logic [7:0] pcb,
  input  logic       bad,
  output act_t       act
);

  always_comb begin
    act = decode_frame(pcb, bad);
  end

endmodule

// File: rtl/t1r_link_state.sv
module t1r_link_state
  import t1r_pkg::*;
#(
  parameter logic [7:0] IFS_DEFAULT = 8'h20,
  parameter logic [7:0] WTX_DEFAULT = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  act_t       act,
  input  logic [7:0] data,
  output logic [7:0] ifs_cur,
  output logic [7:0] wtx_cur,
  output logic       chain_open,
  output logic       seq_last,
  output logic       app_req
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ifs_cur    <= IFS_DEFAULT;
      wtx_cur    <= WTX_DEFAULT;
      chain_open <= 1'b0;
      seq_last   <= 1'b0;
      app_req    <= 1'b0;
    end else begin
      app_req <= accept & act.app;
      if (accept) begin
        if (act.resync) begin
          ifs_cur    <= IFS_DEFAULT;
          wtx_cur    <= WTX_DEFAULT;
          chain_open <= 1'b0;
          seq_last   <= 1'b0;
        end
        if (act.set_ifs)     ifs_cur    <= data;
        if (act.set_wtx)     wtx_cur    <= data;
        if (act.open_chain)  chain_open <= 1'b1;
        if (act.close_chain) chain_open <= 1'b0;
        if (act.upd_seq)     seq_last   <= act.seq;
      end
    end
  end

  AST_RESYNC_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && act.resync |=> ifs_cur == IFS_DEFAULT && !chain_open && !seq_last); // R7
  AST_APP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    app_req |-> !chain_open); // R9
  AST_IGNORED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !act.reply && !act.app |=> $stable(ifs_cur) && $stable(wtx_cur) && $stable(chain_open)); // R10

endmodule

// File: rtl/t1r_reply_tx.sv
module t1r_reply_tx
  import t1r_pkg::*;
#(
  parameter int GUARD_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [GUARD_W-1:0] guard_cycles,
  input  logic               start,
  input  logic [7:0]         nad,
  input  logic [7:0]         pcb,
  input  logic               has_data,
  input  logic [7:0]         data,
  output logic               busy,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [7:0]         out_data,
  output logic               out_last
);

  localparam int HDR_N = 4;
  localparam int IDX_W = $clog2(HDR_N + 1);

  typedef enum logic [1:0] {TX_IDLE, TX_GUARD, TX_SEND} tx_st_e;

  tx_st_e                 st;
  logic [GUARD_W-1:0]     wait_cnt;
  logic [GUARD_W-1:0]     guard_q;
  logic [GUARD_W:0]       elapsed;
  logic [HDR_N-1:0][7:0]  hdr;
  logic [IDX_W-1:0]       idx;
  logic [IDX_W-1:0]       nbody;
  logic [7:0]             chk;
  logic                   beat;
  logic                   first_beat;

  assign busy       = (st != TX_IDLE);
  assign out_valid  = (st == TX_SEND);
  assign out_last   = (idx == nbody);
  assign out_data   = out_last ? chk : hdr[idx[1:0]];
  assign beat       = out_valid & out_ready;
  assign first_beat = out_valid & (idx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= TX_IDLE;
      wait_cnt <= '0;
      guard_q  <= '0;
      elapsed  <= '0;
      hdr      <= '0;
      idx      <= '0;
      nbody    <= '0;
      chk      <= '0;
    end else begin
      unique case (st)
        TX_IDLE: begin
          if (start) begin
            hdr[0]   <= swap_nibbles(nad);
            hdr[1]   <= pcb;
            hdr[2]   <= {7'd0, has_data};
            hdr[3]   <= data;
            nbody    <= has_data ? IDX_W'(4) : IDX_W'(3);
            idx      <= '0;
            chk      <= '0;
            wait_cnt <= guard_cycles;
            guard_q  <= guard_cycles;
            elapsed  <= '0;
            st       <= TX_GUARD;
          end
        end
        TX_GUARD: begin
          if (elapsed != '1) elapsed <= elapsed + 1'b1;
          if (wait_cnt == '0) st <= TX_SEND;
          else                wait_cnt <= wait_cnt - 1'b1;
        end
        TX_SEND: begin
          if (beat) begin
            if (out_last) begin
              st <= TX_IDLE;
            end else begin
              chk <= lrc_step(chk, hdr[idx[1:0]]);
              idx <= idx + 1'b1;
            end
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R13
  AST_GUARD_MET: assert property (@(posedge clk) disable iff (!rst_n)
    first_beat |-> elapsed > {1'b0, guard_q}); // R12
  AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    beat && out_last |=> !out_valid); // R11

endmodule

// File: rtl/t1_link_responder.sv
module t1_link_responder
  import t1r_pkg::*;
#(
  parameter int         GUARD_W     = 16,
  parameter logic [7:0] IFS_DEFAULT = 8'h20,
  parameter logic [7:0] WTX_DEFAULT = 8'h01
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [GUARD_W-1:0] guard_cycles,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_nad,
  input  logic [7:0]         in_pcb,
  input  logic [7:0]         in_data,
  input  logic               in_bad,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [7:0]         out_data,
  output logic               out_last,
  output logic               app_req,
  output logic [7:0]         ifs_cur,
  output logic [7:0]         wtx_cur,
  output logic               chain_open,
  output logic               seq_last
);

  act_t act;
  logic accept;
  logic tx_busy;
  logic tx_start;

  assign in_ready = ~tx_busy;
  assign accept   = in_valid & in_ready;
  assign tx_start = accept & act.reply;

  t1r_classify u_classify (
    .pcb (in_pcb),
    .bad (in_bad),
    .act (act)
  );

  t1r_link_state #(
    .IFS_DEFAULT (IFS_DEFAULT),
    .WTX_DEFAULT (WTX_DEFAULT)
  ) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .act        (act),
    .data       (in_data),
    .ifs_cur    (ifs_cur),
    .wtx_cur    (wtx_cur),
    .chain_open (chain_open),
    .seq_last   (seq_last),
    .app_req    (app_req)
  );

  t1r_reply_tx #(
    .GUARD_W (GUARD_W)
  ) u_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .guard_cycles (guard_cycles),
    .start        (tx_start),
    .nad          (in_nad),
    .pcb          (act.pcb),
    .has_data     (act.has_data),
    .data         (in_data),
    .busy         (tx_busy),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .out_last     (out_last)
  );

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R13
  AST_NO_REPLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !act.reply |=> in_ready && !out_valid); // R10

endmodule

// File: tb/t1_link_responder_tb.sv
`timescale 1ns/1ps
module t1_link_responder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] guard_cycles;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_nad, in_pcb, in_data;
  logic        in_bad;
  logic        out_valid, out_ready, out_last;
  logic [7:0]  out_data;
  logic        app_req;
  logic [7:0]  ifs_cur, wtx_cur;
  logic        chain_open, seq_last;

  always #4 clk = ~clk;

  t1_link_responder dut_i (
    .clk(clk), .rst_n(rst_n), .guard_cycles(guard_cycles),
    .in_valid(in_valid), .in_ready(in_ready), .in_nad(in_nad), .in_pcb(in_pcb),
    .in_data(in_data), .in_bad(in_bad), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .app_req(app_req), .ifs_cur(ifs_cur),
    .wtx_cur(wtx_cur), .chain_open(chain_open), .seq_last(seq_last)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] got [8];
  logic       got_last [8];
  int         n_got;
  int         first_at;
  logic       app1, app2, rdy1;
  logic       bp_mode = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Send one frame and gather whatever reply follows.
  task automatic xfer(input logic [7:0] nad, input logic [7:0] pcb, input logic [7:0] data,
                      input logic bad, input int maxcyc);
    logic       stalled;
    logic [7:0] held;
    stalled = 1'b0;
    held    = '0;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_nad = nad; in_pcb = pcb; in_data = data; in_bad = bad; in_valid = 1'b1;
    @(posedge clk);
    n_got = 0; first_at = -1;
    for (int c = 1; c <= maxcyc; c++) begin
      @(negedge clk);
      if (c == 1) begin
        in_valid = 1'b0;
        app1 = app_req;
        rdy1 = in_ready;
      end
      if (c == 2) app2 = app_req;
      if (stalled) begin
        check("R13 stall hold valid", out_valid, 1);
        check("R13 stall hold data", out_data, held);
      end
      out_ready = bp_mode ? c[0] : 1'b1;
      stalled = out_valid && !out_ready;
      held = out_data;
      if (out_valid && out_ready) begin
        if (first_at < 0) first_at = c;
        got[n_got] = out_data;
        got_last[n_got] = out_last;
        n_got++;
        if (out_last || n_got == 8) break;
      end
    end
    out_ready = 1'b1;
  endtask

  task automatic cmp_frame(input string tag, input int nh, input logic [7:0] b0,
                           input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3);
    logic [7:0] e [5];
    logic [7:0] x;
    e[0] = b0; e[1] = b1; e[2] = b2; e[3] = b3;
    x = 8'h00;
    for (int i = 0; i < nh; i++) x = x ^ e[i];
    e[nh] = x;
    check({tag, " byte count"}, n_got, nh + 1);
    if (n_got == nh + 1) begin
      for (int i = 0; i <= nh; i++) begin
        check({tag, " byte"}, got[i], e[i]);
        check({tag, " last flag R11"}, got_last[i], (i == nh));
      end
    end
  endtask

  task automatic t_reset;
    check("R1 in_ready", in_ready, 1);
    check("R1 out_valid", out_valid, 0);
    check("R1 ifs", ifs_cur, 8'h20);
    check("R1 wtx", wtx_cur, 8'h01);
    check("R1 chain", chain_open, 0);
    check("R1 seq", seq_last, 0);
  endtask

  task automatic t_chain_ack;
    xfer(8'h21, 8'h20, 8'h00, 1'b0, 40);
    cmp_frame("R3 ack seq0", 3, 8'h12, 8'h80, 8'h00, 8'h00);
    check("R3 chain open", chain_open, 1);
    check("R3 seq0", seq_last, 0);
    xfer(8'h21, 8'h60, 8'h00, 1'b0, 40);
    cmp_frame("R3 ack seq1", 3, 8'h12, 8'h90, 8'h00, 8'h00);
    check("R3 seq1", seq_last, 1);
    xfer(8'h12, 8'h20, 8'h00, 1'b0, 40);
    cmp_frame("R2 swap 12", 3, 8'h21, 8'h80, 8'h00, 8'h00);
    xfer(8'h5A, 8'h60, 8'h00, 1'b0, 40);
    cmp_frame("R2 swap any", 3, 8'hA5, 8'h90, 8'h00, 8'h00);
  endtask

  task automatic t_bad;
    xfer(8'h21, 8'h00, 8'h00, 1'b1, 40);
    cmp_frame("R4 bad seq0", 3, 8'h12, 8'h81, 8'h00, 8'h00);
    check("R4 value 93", got[3], 8'h93);
    xfer(8'h21, 8'h40, 8'h00, 1'b1, 40);
    cmp_frame("R4 bad seq1", 3, 8'h12, 8'h91, 8'h00, 8'h00);
    check("R4 value 83", got[3], 8'h83);
    xfer(8'h21, 8'hC1, 8'h77, 1'b1, 40);
    cmp_frame("R4 bad sreq", 3, 8'h12, 8'h81, 8'h00, 8'h00);
    check("R4 ifs held", ifs_cur, 8'h20);
    check("R4 seq held", seq_last, 1);
    check("R4 chain held", chain_open, 1);
  endtask

  task automatic t_ifs;
    xfer(8'h21, 8'hC1, 8'h58, 1'b0, 40);
    cmp_frame("R5 size reply", 4, 8'h12, 8'hE1, 8'h01, 8'h58);
    check("R5 value AA", got[4], 8'hAA);
    check("R5 ifs stored", ifs_cur, 8'h58);
  endtask

  task automatic t_wtx;
    xfer(8'h21, 8'hC3, 8'h05, 1'b0, 40);
    cmp_frame("R6 wait reply", 4, 8'h12, 8'hE3, 8'h01, 8'h05);
    check("R6 wtx stored", wtx_cur, 8'h05);
  endtask

  task automatic t_ignore;
    xfer(8'h21, 8'h80, 8'h00, 1'b0, 20);
    check("R10 rblock no bytes", n_got, 0);
    check("R10 rblock ready", rdy1, 1);
    xfer(8'h21, 8'hE1, 8'h33, 1'b0, 20);
    check("R10 sresp no bytes", n_got, 0);
    check("R10 ifs kept", ifs_cur, 8'h58);
    check("R10 wtx kept", wtx_cur, 8'h05);
    check("R10 chain kept", chain_open, 1);
  endtask

  task automatic t_abort;
    xfer(8'h21, 8'hC2, 8'h00, 1'b0, 40);
    cmp_frame("R8 abort reply", 3, 8'h12, 8'hE2, 8'h00, 8'h00);
    check("R8 chain closed", chain_open, 0);
  endtask

  task automatic t_app;
    xfer(8'h21, 8'h20, 8'h00, 1'b0, 40);
    check("R9 prep chain", chain_open, 1);
    xfer(8'h21, 8'h40, 8'h00, 1'b0, 20);
    check("R9 no bytes", n_got, 0);
    check("R9 app pulse", app1, 1);
    check("R9 app one cycle", app2, 0);
    check("R9 chain closed", chain_open, 0);
    check("R9 seq loaded", seq_last, 1);
  endtask

  task automatic t_resync;
    check("R7 prep ifs", ifs_cur, 8'h58);
    xfer(8'h21, 8'hC0, 8'h00, 1'b0, 40);
    cmp_frame("R7 resync reply", 3, 8'h12, 8'hE0, 8'h00, 8'h00);
    check("R7 ifs default", ifs_cur, 8'h20);
    check("R7 wtx default", wtx_cur, 8'h01);
    check("R7 seq cleared", seq_last, 0);
    check("R7 chain cleared", chain_open, 0);
  endtask

  task automatic t_guard;
    guard_cycles = 16'd20;
    xfer(8'h21, 8'h20, 8'h00, 1'b0, 60);
    check("R12 guard 20 respected", (first_at >= 21), 1);
    cmp_frame("R12 guard 20 frame", 3, 8'h12, 8'h80, 8'h00, 8'h00);
    guard_cycles = 16'd0;
    xfer(8'h21, 8'h60, 8'h00, 1'b0, 40);
    check("R12 guard 0 first byte", (first_at >= 1), 1);
    cmp_frame("R12 guard 0 frame", 3, 8'h12, 8'h90, 8'h00, 8'h00);
    guard_cycles = 16'd3;
  endtask

  task automatic t_backpressure;
    bp_mode = 1'b1;
    xfer(8'h21, 8'hC1, 8'h3C, 1'b0, 60);
    bp_mode = 1'b0;
    check("R13 busy blocks input", rdy1, 0);
    cmp_frame("R13 stalled frame", 4, 8'h12, 8'hE1, 8'h01, 8'h3C);
  endtask

  initial begin
    #(8ns * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_nad = '0; in_pcb = '0; in_data = '0;
    in_bad = 1'b0; out_ready = 1'b1; guard_cycles = 16'd3;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_chain_ack;
    t_bad;
    t_ifs;
    t_wtx;
    t_ignore;
    t_abort;
    t_app;
    t_ifs;
    t_resync;
    t_guard;
    t_backpressure;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule